// File: doc/BRIEF.md
# Bus master wait-state cycle controller

This block drives an external slave over a 16-bit parallel data bus using separate write and read strobes. A host or DMA engine places outgoing words in a transmit queue. Each word leaves in its own write cycle. The strobe stays asserted for a programmable number of wait states plus one clock. When a wait-enable control input is set, the slave can stretch the cycle through its WAIT line.

A level-sensitive read-mode input tells the controller to run read cycles instead of write cycles. Each read cycle samples the slave's data bus on its last strobe clock and stores the word in a receive queue, which the host drains through a pop port. The slave's request line gates write cycles: while it stays high and words remain, write cycles follow each other with a single idle clock between them.

The controller is a three-state machine:
- IDLE: no strobe.
- WRITE: write strobe high, head word of the transmit queue on the bus.
- READ: read strobe high.

It has four transitions:
- IDLE→WRITE when read mode is off, the transmit queue is not empty and the slave request is high.
- IDLE→READ when read mode is on and the receive queue is not full.
- WRITE→IDLE when the cycle completes; the sent word is popped.
- READ→IDLE when the cycle completes; the sampled word is pushed.

The WAIT line is registered on the falling clock edge and the sample is used on the next rising edge.

Top module: `xbm_cycle_master`

## Requirements
- R1: During and after reset both strobes are low, `bus_dout` is 0, `tx_full` is 0 and `rx_empty` is 1.
- R2: With read mode off and `slv_req` high, a word pushed into an empty transmit queue on clock edge k raises `bus_wr` after edge k+1. `bus_dout` carries that word while `bus_wr` is high.
- R3: With `cfg_wait_en` = 0, every strobe stays high for exactly `cfg_ws`+1 clocks, whatever `slv_wait` does.
- R4: With `cfg_wait_en` = 1, suppose `slv_wait` is first sampled high (on a falling edge) during strobe clock j, counting from 0. The strobe then lasts j+1+`cfg_ws` clocks.
- R5: With `cfg_wait_en` = 1 and `slv_wait` already high before the strobe rises, the strobe lasts `cfg_ws`+1 clocks, the same as with waiting disabled. No strobe is ever shorter than `cfg_ws`+1 clocks.
- R6: Words leave in push order. While `slv_req` stays high and words remain, the next write strobe rises after exactly one idle clock. While `slv_req` is low, no write cycle starts.
- R7: The transmit queue holds 8 words and `tx_full` is 1 when it holds 8. A push while full is ignored. No write strobe occurs while the queue is empty.
- R8: While `rd_mode` is 1, no write cycle starts and read cycles run with the same `cfg_ws`+1 strobe length. The value of `bus_din` on the last strobe clock is stored. Stored words come out of `rx_rd_data` in capture order, one per `rx_rd_en` pulse.
- R9: The receive queue holds 8 words. While it is full (`rx_full` = 1), no read strobe starts.
- R10: `bus_wr` and `bus_rd` are never high together, and at least one clock with both low separates consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wait_en | input | 1 | 1: cycle end waits for `slv_wait` high |
| cfg_ws | input | 4 | Wait-state count; base strobe length is this value plus one |
| rd_mode | input | 1 | Level: 1 runs read cycles, 0 runs write cycles |
| tx_wr_en | input | 1 | Push strobe for the transmit queue |
| tx_wr_data | input | 16 | Word to push |
| tx_full | output | 1 | Transmit queue holds 8 words |
| rx_rd_en | input | 1 | Pop strobe for the receive queue |
| rx_rd_data | output | 16 | Oldest word in the receive queue |
| rx_empty | output | 1 | Receive queue holds no word |
| rx_full | output | 1 | Receive queue holds 8 words |
| slv_req | input | 1 | Slave request; gates write cycles |
| slv_wait | input | 1 | Slave wait; high allows the cycle to finish |
| bus_din | input | 16 | Data from the slave during reads |
| bus_dout | output | 16 | Data to the slave; 0 outside write strobes |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |

## Verification
A write strobe is due one rising edge after the push edge. The bench therefore checks that it is still low right after the push and high after the following edge. Strobe length is counted in clocks sampled 1 ns after each rising edge. For R4, the bench raises WAIT 1 ns after the edge that opens strobe clock j, so the falling-edge sample of that same clock sees it and the expected length is j+1+WS. Read data is due in the receive queue on the edge where the read strobe falls, so the bench changes `bus_din` right after each strobe rise and reads the queue only once reads have stopped.

// File: rtl/xbm_pkg.sv
`timescale 1ns/1ps
package xbm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } xbm_state_e;
endpackage

// File: rtl/xbm_fifo.sv
`timescale 1ns/1ps
module xbm_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full); // R7
endmodule

// File: rtl/xbm_wait_sample.sv
`timescale 1ns/1ps
module xbm_wait_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic wait_in,
    output logic smp
);
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) smp <= 1'b0;
        else        smp <= strobe && wait_in;
    end
endmodule

// File: rtl/xbm_cycle_fsm.sv
`timescale 1ns/1ps
module xbm_cycle_fsm
    import xbm_pkg::*;
#(
    parameter int WS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wait_en,
    input  logic [WS_W-1:0] ws,
    input  logic            rd_mode,
    input  logic            tx_empty,
    input  logic            rx_full,
    input  logic            slv_req,
    input  logic            wait_smp,
    output logic            bus_wr,
    output logic            bus_rd,
    output logic            tx_pop,
    output logic            rx_push
);
    xbm_state_e      state_q, state_d;
    logic [WS_W-1:0] cnt_q;
    logic            armed_q;
    logic            count_en, done;

    assign count_en = !wait_en || armed_q || wait_smp;
    assign done     = (state_q != ST_IDLE) && count_en && (cnt_q == ws);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (state_q == ST_IDLE || done) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            if (count_en) cnt_q   <= cnt_q + 1'b1;
            if (wait_smp) armed_q <= 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_mode) begin
                    if (!rx_full) state_d = ST_READ;
                end else if (!tx_empty && slv_req) begin
                    state_d = ST_WRITE;
                end
            end
            ST_WRITE: if (done) state_d = ST_IDLE;
            ST_READ:  if (done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_wr  = (state_q == ST_WRITE);
        bus_rd  = (state_q == ST_READ);
        tx_pop  = (state_q == ST_WRITE) && done;
        rx_push = (state_q == ST_READ) && done;
    end

    AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop || rx_push) |=> !(bus_wr || bus_rd)); // R10
    AST_NO_EMPTY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> !tx_empty); // R7
    AST_NO_RX_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full); // R9
endmodule

// File: rtl/xbm_cycle_master.sv
`timescale 1ns/1ps
module xbm_cycle_master #(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 8,
    parameter int WS_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wait_en,
    input  logic [WS_W-1:0]   cfg_ws,
    input  logic              rd_mode,
    input  logic              tx_wr_en,
    input  logic [DATA_W-1:0] tx_wr_data,
    output logic              tx_full,
    input  logic              rx_rd_en,
    output logic [DATA_W-1:0] rx_rd_data,
    output logic              rx_empty,
    output logic              rx_full,
    input  logic              slv_req,
    input  logic              slv_wait,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_wr,
    output logic              bus_rd
);
    localparam int LEN_W = WS_W + 2;

    logic              tx_empty, tx_pop, rx_push, wait_smp, strobe_any;
    logic [DATA_W-1:0] tx_head;
    logic [LEN_W-1:0]  hi_len;

    assign strobe_any = bus_wr || bus_rd;
    assign bus_dout   = bus_wr ? tx_head : '0;

    xbm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(tx_wr_en), .din(tx_wr_data), .pop(tx_pop),
        .head(tx_head), .full(tx_full), .empty(tx_empty)
    );

    xbm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .din(bus_din), .pop(rx_rd_en),
        .head(rx_rd_data), .full(rx_full), .empty(rx_empty)
    );

    xbm_wait_sample u_wait (
        .clk(clk), .rst_n(rst_n),
        .strobe(strobe_any), .wait_in(slv_wait), .smp(wait_smp)
    );

    xbm_cycle_fsm #(.WS_W(WS_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .wait_en(cfg_wait_en), .ws(cfg_ws), .rd_mode(rd_mode),
        .tx_empty(tx_empty), .rx_full(rx_full), .slv_req(slv_req),
        .wait_smp(wait_smp),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .tx_pop(tx_pop), .rx_push(rx_push)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    hi_len <= '0;
        else if (!strobe_any)          hi_len <= '0;
        else if (hi_len != '1)         hi_len <= hi_len + 1'b1;
    end

    AST_LEN_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(strobe_any) && !$past(cfg_wait_en)) |->
        ($past(hi_len) == LEN_W'($past(cfg_ws)))); // R3
    AST_LEN_MINIMUM: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_any) |-> ($past(hi_len) >= LEN_W'($past(cfg_ws)))); // R5
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr) |-> !$past(bus_rd)); // R10
endmodule

// File: tb/xbm_cycle_master_bench.sv
`timescale 1ns/1ps
module xbm_cycle_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wait_en = 1'b0;
    logic [3:0]  cfg_ws = 4'd0;
    logic        rd_mode = 1'b0;
    logic        tx_wr_en = 1'b0;
    logic [15:0] tx_wr_data = '0;
    logic        tx_full;
    logic        rx_rd_en = 1'b0;
    logic [15:0] rx_rd_data;
    logic        rx_empty, rx_full;
    logic        slv_req = 1'b0;
    logic        slv_wait = 1'b0;
    logic [15:0] bus_din = '0;
    logic [15:0] bus_dout;
    logic        bus_wr, bus_rd;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    xbm_cycle_master u_xbm_cycle_master (
        .clk(clk), .rst_n(rst_n), .cfg_wait_en(cfg_wait_en), .cfg_ws(cfg_ws),
        .rd_mode(rd_mode), .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
        .tx_full(tx_full), .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
        .rx_empty(rx_empty), .rx_full(rx_full), .slv_req(slv_req),
        .slv_wait(slv_wait), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_wr(bus_wr), .bus_rd(bus_rd)
    );

    // {ws[3:0], wait_en, wait_pre_high, wait_delay[4:0], expected_len[4:0]}
    localparam logic [15:0] VEC [8] = '{
        {4'd0,  1'b0, 1'b0, 5'd3, 5'd1},
        {4'd3,  1'b0, 1'b0, 5'd2, 5'd4},
        {4'd15, 1'b0, 1'b0, 5'd5, 5'd16},
        {4'd2,  1'b1, 1'b0, 5'd0, 5'd3},
        {4'd2,  1'b1, 1'b0, 5'd4, 5'd7},
        {4'd0,  1'b1, 1'b0, 5'd6, 5'd7},
        {4'd5,  1'b1, 1'b1, 5'd0, 5'd6},
        {4'd7,  1'b1, 1'b0, 5'd1, 5'd9}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push_word(input logic [15:0] d);
        tx_wr_en   = 1'b1;
        tx_wr_data = d;
        tick();
        tx_wr_en   = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int len, c, rises, prev, idle_run, gap_bad, highs;
        logic [15:0] got [3];
        logic [15:0] last;

        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 wr", bus_wr, 0);
        check("R1 rd", bus_rd, 0);
        check("R1 dout", bus_dout, 0);
        check("R1 txfull", tx_full, 0);
        check("R1 rxempty", rx_empty, 1);
        rst_n = 1'b1;
        tick();
        check("R1 wr after", bus_wr, 0);

        // Table of strobe lengths: R2, R3, R4, R5
        for (int i = 0; i < 8; i++) begin
            cfg_ws      = VEC[i][15:12];
            cfg_wait_en = VEC[i][11];
            slv_wait    = VEC[i][10];
            slv_req     = 1'b1;
            tick();
            push_word(16'hC000 + 16'(i));
            check("R2 not yet", bus_wr, 0);
            tick();
            check("R2 start", bus_wr, 1);
            check("R2 data", bus_dout, 16'hC000 + 16'(i));
            len = 0;
            c = 0;
            while (bus_wr && len < 100) begin
                len++;
                if (c == int'(VEC[i][9:5])) slv_wait = 1'b1;
                c++;
                tick();
            end
            if (!VEC[i][11])     check("R3 len", len, VEC[i][4:0]);
            else if (VEC[i][10]) check("R5 len", len, VEC[i][4:0]);
            else                 check("R4 len", len, VEC[i][4:0]);
            check("R10 gap", bus_wr | bus_rd, 0);
            slv_wait = 1'b0;
        end

        // R6 back-to-back with one idle clock, order kept
        cfg_wait_en = 1'b0;
        cfg_ws = 4'd1;
        rises = 0; prev = 0; idle_run = 0; gap_bad = 0;
        for (int t = 0; t < 16; t++) begin
            tx_wr_en   = (t < 3);
            tx_wr_data = 16'hD000 + 16'(t);
            tick();
            if (bus_wr && prev == 0) begin
                if (rises < 3) got[rises] = bus_dout;
                if (rises > 0 && idle_run != 1) gap_bad++;
                rises++;
            end
            idle_run = bus_wr ? 0 : idle_run + 1;
            prev = bus_wr;
        end
        tx_wr_en = 1'b0;
        check("R6 count", rises, 3);
        check("R6 gap", gap_bad, 0);
        check("R6 order0", got[0], 16'hD000);
        check("R6 order1", got[1], 16'hD001);
        check("R6 order2", got[2], 16'hD002);

        // R6 request low holds the write
        slv_req = 1'b0;
        push_word(16'hE000);
        highs = 0;
        for (int t = 0; t < 6; t++) begin
            tick();
            if (bus_wr) highs++;
        end
        check("R6 req low", highs, 0);
        slv_req = 1'b1;
        tick();
        check("R6 req high", bus_wr, 1);
        check("R6 req data", bus_dout, 16'hE000);
        while (bus_wr) tick();

        // R7 fill: ninth push dropped
        slv_req = 1'b0;
        cfg_ws = 4'd0;
        for (int k = 0; k < 9; k++) push_word(16'hF000 + 16'(k));
        check("R7 full", tx_full, 1);
        slv_req = 1'b1;
        rises = 0; prev = 0; last = '0;
        for (int t = 0; t < 30; t++) begin
            tick();
            if (bus_wr && prev == 0) begin
                rises++;
                last = bus_dout;
            end
            prev = bus_wr;
        end
        check("R7 count", rises, 8);
        check("R7 last", last, 16'hF007);
        check("R7 idle empty", bus_wr, 0);

        // R8 / R9 reads until receive queue full
        rd_mode = 1'b1;
        rises = 0; prev = 0; highs = 0; gap_bad = 0;
        for (int t = 0; t < 30; t++) begin
            tick();
            if (bus_wr && bus_rd) gap_bad++;
            if (bus_rd) highs++;
            if (bus_rd && prev == 0) begin
                bus_din = 16'hB000 + 16'(rises);
                rises++;
            end
            prev = bus_rd;
        end
        check("R9 reads", rises, 8);
        check("R8 len", highs, 8);
        check("R9 full", rx_full, 1);
        check("R10 excl", gap_bad, 0);
        check("R8 no write", bus_wr, 0);
        rd_mode = 1'b0;
        tick();
        for (int k = 0; k < 8; k++) begin
            check("R8 data", rx_rd_data, 16'hB000 + 16'(k));
            rx_rd_en = 1'b1;
            tick();
            rx_rd_en = 1'b0;
        end
        check("R8 drained", rx_empty, 1);

        // R8 read strobe length with wait states
        cfg_ws = 4'd3;
        rd_mode = 1'b1;
        tick();
        check("R8 rd start", bus_rd, 1);
        rd_mode = 1'b0;
        len = 0;
        while (bus_rd && len < 100) begin
            len++;
            tick();
        end
        check("R8 rd len", len, 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule